// File: doc/BRIEF.md
# Register Ready-Cycle Tracker

This block keeps, for each of eight architectural registers, the cycle number at which the register's latest planned result becomes ready. A scheduler that has just committed an instruction presents the destination register, the issue cycle and a latency class. The block then adds the latency to the issue cycle and stores the sum as that register's ready stamp. The new stamp always replaces the old one, even when it is earlier.

A second, independent port asks whether a given register is ready by a given cycle. The answer is combinational and is based on the stamps as they stand before the current clock edge. The block also drives a registered overall-latency value. That value is the largest ready stamp held across all registers, and it trails the stamp storage by one clock. Stamps are 8 bits wide, and any sum above the largest stamp value is clamped to that value.

Top module: `ready_cycle_tracker`

## Requirements
- R1: While rst_n is low at a rising clock edge, every stamp and the overall latency become 0, so every register then reads as ready at query cycle 0.
- R2: A write (wr_en high at a rising edge) overwrites the addressed register's stamp with the computed retirement cycle, even when the new value is smaller than the old one.
- R3: The retirement cycle is wr_issue plus a latency chosen by wr_lat_sel: code 0 adds 1, code 1 adds 3, and codes 2 and 3 add 4.
- R4: When wr_issue plus the latency exceeds 255, the stored stamp is 255.
- R5: q_avail is 1 exactly when the stamp of register q_reg is less than or equal to q_cycle; it follows q_reg and q_cycle with no clock delay.
- R6: When a write and a query address the same register in the same cycle, q_avail is based on the old stamp; the new stamp decides the answer from the next cycle on.
- R7: overall_latency is a register loaded on every rising edge with the largest stamp held before that edge, so it lags a write by one clock relative to q_avail.
- R8: Stamps of registers not addressed by a write keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Commit a new ready stamp this cycle |
| wr_reg | input | 3 | Destination register id of the commit |
| wr_issue | input | 8 | Issue cycle of the committed instruction |
| wr_lat_sel | input | 2 | Latency class: 0 means 1, 1 means 3, 2 or 3 means 4 |
| q_reg | input | 3 | Register id being queried |
| q_cycle | input | 8 | Cycle the query is asked about |
| q_avail | output | 1 | Queried register is ready by q_cycle |
| overall_latency | output | 8 | Largest stamp over all registers, registered |

## Verification
A wrong stamp in one register shows up on q_avail as soon as that register is queried at a cycle lying between the right and the wrong value. The bench therefore probes each written stamp at both the stamp itself and one below it. A stamp that keeps the larger of old and new values instead of replacing it is caught by the first query after a smaller write. A fault in the maximum tree or its register shows up on overall_latency one clock after the stamps change, and the bench compares that output on every cycle.

// File: rtl/rdy_pkg.sv
// Shared types for the ready-cycle tracker.
// Assumes the latency classes below are the only ones a committer uses.
package rdy_pkg;

    // Latency class carried with each commit
    typedef enum logic [1:0] {
        LAT_ONE      = 2'd0,
        LAT_THREE    = 2'd1,
        LAT_FOUR     = 2'd2,
        LAT_FOUR_ALT = 2'd3
    } lat_sel_e;

    localparam int LAT_W       = 3;
    localparam int LAT_SHORT   = 1;
    localparam int LAT_MUL     = 3;
    localparam int LAT_MUL_HI  = 4;

endpackage

// File: rtl/rdy_stamp_calc.sv
// Computes the retirement stamp of a commit: issue cycle plus the latency of
// its class, clamped to the largest value a stamp can hold.
// Assumes W is at least LAT_W so the latency fits the adder.
module rdy_stamp_calc #(
    parameter int W = 8
) (
    input  logic              [W-1:0] issue,
    input  rdy_pkg::lat_sel_e         sel,
    output logic              [W-1:0] stamp
);
    import rdy_pkg::*;

    localparam int PAD_W = W + 1 - LAT_W;

    logic [LAT_W-1:0] lat;
    logic [W:0]       sum;

    // Decode the latency class into a cycle count
    always_comb begin
        case (sel)
            LAT_ONE:   lat = LAT_W'(LAT_SHORT);
            LAT_THREE: lat = LAT_W'(LAT_MUL);
            default:   lat = LAT_W'(LAT_MUL_HI);
        endcase
    end

    // Add with one guard bit and clamp on carry out
    always_comb begin
        sum   = {1'b0, issue} + {{PAD_W{1'b0}}, lat};
        stamp = sum[W] ? {W{1'b1}} : sum[W-1:0];
    end

endmodule

// File: rtl/rdy_stamp_file.sv
// Holds one ready stamp per register and overwrites the addressed one on a
// commit. Assumes NREG is a power of two addressed by IDW bits.
module rdy_stamp_file #(
    parameter int NREG = 8,
    parameter int W    = 8,
    parameter int IDW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDW-1:0]    wr_reg,
    input  logic [W-1:0]      wr_stamp,
    output logic [NREG*W-1:0] stamps
);

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        logic [W-1:0] ent_q;
        logic         hit;

        // Select this entry when the commit addresses it
        always_comb hit = wr_en && (wr_reg == IDW'(g));

        // Replace the stamp on a commit; clear on reset
        always_ff @(posedge clk) begin
            if (!rst_n)   ent_q <= '0;
            else if (hit) ent_q <= wr_stamp;
        end

        assign stamps[g*W +: W] = ent_q;

        // R2
        wr_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_reg == IDW'(g)) |=> (stamps[g*W +: W] == $past(wr_stamp)));

        // R8
        untouched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_reg == IDW'(g)) |=> $stable(stamps[g*W +: W]));
    end

endmodule

// File: rtl/rdy_max_tree.sv
// Reduces all stamps to their maximum through a binary tree of comparators
// and registers the result. Assumes NREG is a power of two.
module rdy_max_tree #(
    parameter int NREG = 8,
    parameter int W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG*W-1:0] stamps,
    output logic [W-1:0]      max_q
);
    localparam int NODES = 2 * NREG - 1;
    localparam int INNER = NREG - 1;

    logic [W-1:0] node [NODES];

    // Leaves of the tree are the stamps themselves
    for (genvar l = 0; l < NREG; l++) begin : g_leaf
        assign node[INNER + l] = stamps[l*W +: W];
    end

    // Each inner node keeps the larger of its two children
    for (genvar n = 0; n < INNER; n++) begin : g_node
        assign node[n] = (node[2*n+1] >= node[2*n+2]) ? node[2*n+1] : node[2*n+2];
    end

    // Register the root of the tree
    always_ff @(posedge clk) begin
        if (!rst_n) max_q <= '0;
        else        max_q <= node[0];
    end

    for (genvar c = 0; c < NREG; c++) begin : g_chk
        // R7
        max_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (max_q >= $past(stamps[c*W +: W])));
    end

endmodule

// File: rtl/rdy_query.sv
// Answers whether one register is ready by a given cycle, using the stamps
// held before the current edge. Purely combinational.
module rdy_query #(
    parameter int NREG = 8,
    parameter int W    = 8,
    parameter int IDW  = $clog2(NREG)
) (
    input  logic [NREG*W-1:0] stamps,
    input  logic [IDW-1:0]    q_reg,
    input  logic [W-1:0]      q_cycle,
    output logic              q_avail
);
    logic [W-1:0] sel_stamp;

    // Pick the addressed stamp and compare it with the query cycle
    always_comb begin
        sel_stamp = stamps[q_reg*W +: W];
        q_avail   = (sel_stamp <= q_cycle);
    end

endmodule

// File: rtl/ready_cycle_tracker.sv
// Top of the register ready-cycle tracker: stamp calculation on commit,
// per-register stamp storage, availability query and registered maximum.
// Assumes at most one commit per clock; reset is synchronous, active low.
module ready_cycle_tracker #(
    parameter int NREG = 8,
    parameter int W    = 8,
    parameter int IDW  = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [IDW-1:0] wr_reg,
    input  logic [W-1:0]   wr_issue,
    input  logic [1:0]     wr_lat_sel,
    input  logic [IDW-1:0] q_reg,
    input  logic [W-1:0]   q_cycle,
    output logic           q_avail,
    output logic [W-1:0]   overall_latency
);
    import rdy_pkg::*;

    logic [W-1:0]      new_stamp;
    logic [NREG*W-1:0] stamps;
    lat_sel_e          sel;

    // Interpret the raw latency code as a class
    always_comb sel = lat_sel_e'(wr_lat_sel);

    rdy_stamp_calc #(.W(W)) u_calc (
        .issue (wr_issue),
        .sel   (sel),
        .stamp (new_stamp)
    );

    rdy_stamp_file #(.NREG(NREG), .W(W), .IDW(IDW)) u_file (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_reg   (wr_reg),
        .wr_stamp (new_stamp),
        .stamps   (stamps)
    );

    rdy_query #(.NREG(NREG), .W(W), .IDW(IDW)) u_query (
        .stamps  (stamps),
        .q_reg   (q_reg),
        .q_cycle (q_cycle),
        .q_avail (q_avail)
    );

    rdy_max_tree #(.NREG(NREG), .W(W)) u_max (
        .clk    (clk),
        .rst_n  (rst_n),
        .stamps (stamps),
        .max_q  (overall_latency)
    );

    // R4
    stamp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (new_stamp > wr_issue || new_stamp == {W{1'b1}}));

endmodule

// File: tb/ready_cycle_tracker_tb.sv
module ready_cycle_tracker_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_reg = '0;
    logic [7:0] wr_issue = '0;
    logic [1:0] wr_lat_sel = '0;
    logic [2:0] q_reg = '0;
    logic [7:0] q_cycle = '0;
    logic       q_avail;
    logic [7:0] overall_latency;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int mdl [8];
    int lat_exp = 0;

    always #5 clk = ~clk;

    ready_cycle_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg),
        .wr_issue(wr_issue), .wr_lat_sel(wr_lat_sel), .q_reg(q_reg),
        .q_cycle(q_cycle), .q_avail(q_avail), .overall_latency(overall_latency)
    );

    function automatic int exp_stamp(int issue, int sel);
        int s;
        s = issue + ((sel == 0) ? 1 : (sel == 1) ? 3 : 4);
        return (s > 255) ? 255 : s;
    endfunction

    function automatic int model_max();
        int m = 0;
        for (int i = 0; i < 8; i++) if (mdl[i] > m) m = mdl[i];
        return m;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check before the rising edge,
    // then advance the model across the edge.
    task automatic step(bit we, int r, int issue, int sel, int qr, int qc, string tag);
        wr_en = we; wr_reg = 3'(r); wr_issue = 8'(issue); wr_lat_sel = 2'(sel);
        q_reg = 3'(qr); q_cycle = 8'(qc);
        #1;
        check(tag, int'(q_avail), (mdl[qr] <= qc) ? 1 : 0);
        check("R7", int'(overall_latency), lat_exp);
        @(posedge clk);
        lat_exp = model_max();
        if (we) mdl[r] = exp_stamp(issue, sel);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mdl[i] = 0;
        void'($urandom(32'd4321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: everything ready at cycle 0 after reset
        step(0, 0, 0, 0, 3, 0, "R1");
        check("R1", int'(overall_latency), 0);
        // R6: write and query same register, old stamp answers
        step(1, 2, 10, 0, 2, 0, "R6");
        step(0, 0, 0, 0, 2, 10, "R5");
        step(0, 0, 0, 0, 2, 11, "R5");
        // R2: smaller stamp replaces larger
        step(1, 2, 2, 0, 2, 10, "R6");
        step(0, 0, 0, 0, 2, 2, "R2");
        step(0, 0, 0, 0, 2, 3, "R2");
        // R3: latency classes
        step(1, 4, 20, 1, 4, 0, "R3");
        step(1, 5, 20, 2, 4, 22, "R3");
        step(1, 6, 20, 3, 4, 23, "R3");
        step(0, 0, 0, 0, 5, 23, "R3");
        step(0, 0, 0, 0, 5, 24, "R3");
        step(0, 0, 0, 0, 6, 23, "R3");
        step(0, 0, 0, 0, 6, 24, "R3");
        // R4: clamp at 255
        step(1, 7, 254, 2, 0, 0, "R5");
        step(0, 0, 0, 0, 7, 254, "R4");
        step(0, 0, 0, 0, 7, 255, "R4");
        step(1, 1, 255, 0, 7, 255, "R4");
        step(0, 0, 0, 0, 1, 254, "R4");
        // R8: other registers untouched
        step(0, 0, 0, 0, 4, 22, "R8");
        step(0, 0, 0, 0, 4, 23, "R8");
        step(0, 0, 0, 0, 2, 2, "R8");
        // Random mix
        for (int k = 0; k < 400; k++) begin
            int r, qr, qc;
            r  = int'($urandom_range(7, 0));
            qr = (k % 3 == 0) ? r : int'($urandom_range(7, 0));
            qc = (k % 2 == 0) ? mdl[qr] - int'($urandom_range(1, 0)) : int'($urandom_range(255, 0));
            if (qc < 0) qc = 0;
            step(bit'($urandom_range(1, 0)), r, int'($urandom_range(255, 0)),
                 int'($urandom_range(3, 0)), qr, qc, "R5");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule